// File: doc/BRIEF.md
# Load/Store Port Request Sequencer

This block sits between an execution unit and a memory port. It takes one load or store command from the core, carrying an address, a 4-bit access length and, for a store, the write data. It then runs the requester side of a handshaked port. It raises exactly one request line together with an address-valid flag, and it holds the address, the length and the store data unchanged for the whole operation. It waits for the responder to either accept the address or refuse it with an exception.

An accepted load waits for the responder's single-cycle load strobe, which may come any number of cycles later. The load data is captured on that strobe. An accepted store issues a single-cycle store strobe on the cycle after the acceptance and gets no acknowledgement back. The request stays up until the responder drops busy, which happens on the cycle after the strobe. Each operation ends with a one-cycle done pulse to the core, plus a fault flag when the port refused the access. The core may issue a command only while the block is idle and the port's busy line is low. An abort input returns the sequencer to idle and is also passed on to the responder.

The reset input is asynchronous and active low. It is released to the logic through a two-stage synchroniser, so the block leaves reset two clock edges after the reset input goes high.

Top module: `ldst_port_seq`

## Requirements
- R1: At most one of `prt_ld_req` and `prt_st_req` is ever high. `cmd_store`=0 selects a load and `cmd_store`=1 selects a store.
- R2: A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only when the sequencer is idle and `prt_busy` is low. The request line and `prt_addr_vld` go high on the next cycle. While `prt_busy` is high in idle, commands are ignored.
- R3: From the cycle the request is raised until it drops, `prt_addr`, `prt_len` and `prt_st_data` keep the values taken with the command, whatever the command inputs do.
- R4: An exception pulse while waiting for acceptance drops the request on the next cycle, and `rsp_done` and `rsp_fault` are high together on that same cycle for one cycle.
- R5: After acceptance, a load waits any number of cycles for `prt_ld_vld`. It captures `prt_ld_data` on that cycle and pulses `rsp_done` with `rsp_fault` low on the next cycle, with `rsp_rdata` equal to the captured data.
- R6: A store raises `prt_st_vld` for exactly one cycle, the cycle right after `prt_addr_ack`, and never before acceptance. `rsp_done` pulses on the following cycle.
- R7: After the store strobe the store request and address stay up while `prt_busy` is high, and drop on the cycle after `prt_busy` is seen low.
- R8: `prt_kill` follows `cmd_abort`. An abort in any state returns the sequencer to idle on the next cycle with no done pulse, even when it coincides with an acceptance or a load strobe.
- R9: `rsp_rdata` changes only on a load completion. Stores, faults and aborts leave it unchanged.
- R10: After reset, `rsp_done`, `rsp_fault`, `rsp_rdata`, both request lines, `prt_addr_vld` and `prt_st_vld` are all zero, and `cmd_ready` is high when `prt_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Core presents a command |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | AW | Access address |
| cmd_len | input | LW | Access length field |
| cmd_wdata | input | DW | Store data |
| cmd_abort | input | 1 | Abort the operation in flight |
| cmd_ready | output | 1 | Sequencer can take a command |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 1 | Completion was a refused access |
| rsp_rdata | output | DW | Last captured load data |
| prt_ld_req | output | 1 | Load request to the port |
| prt_st_req | output | 1 | Store request to the port |
| prt_addr_vld | output | 1 | Address valid |
| prt_addr | output | AW | Held address |
| prt_len | output | LW | Held access length |
| prt_busy | input | 1 | Port busy from the responder |
| prt_addr_ack | input | 1 | One-cycle address acceptance |
| prt_exc | input | 1 | One-cycle exception (refusal) |
| prt_ld_vld | input | 1 | One-cycle load data strobe |
| prt_ld_data | input | DW | Load data, valid with the strobe |
| prt_st_vld | output | 1 | One-cycle store data strobe |
| prt_st_data | output | DW | Held store data |
| prt_kill | output | 1 | Abort passed on to the responder |

## Verification
An abort can land in the same cycle as a responder event: the acceptance pulse, or a load strobe that arrives with no delay. The bench provokes this by setting the responder delays to zero and raising the abort on the exact cycle that it has computed for the acceptance or the strobe. It also raises an abort while the sequencer is still waiting for acceptance, as a reference case. In all of these cases the abort must win: the request drops on the next cycle, no done pulse follows for ten cycles, and the read data keeps its earlier value. Apart from these cases, the bench sweeps every acceptance delay and every load-strobe delay from 0 to 7 for loads, stores and refused accesses. It compares the cycle of the done pulse with the count computed from those delays.

// File: rtl/ldst_seq_pkg.sv
package ldst_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_ADDR   = 3'd1,
    SQ_LOAD   = 3'd2,
    SQ_STROBE = 3'd3,
    SQ_DRAIN  = 3'd4
  } sq_state_e;
endpackage

// File: rtl/ldst_seq_rstsync.sv
module ldst_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ldst_seq_ctrl.sv
module ldst_seq_ctrl
  import ldst_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  logic      cmd_abort,
  input  logic      op_store,
  input  logic      prt_busy,
  input  logic      prt_addr_ack,
  input  logic      prt_exc,
  input  logic      prt_ld_vld,
  output sq_state_e state,
  output logic      ready,
  output logic      accept,
  output logic      evt_done,
  output logic      evt_fault,
  output logic      evt_load
);
  sq_state_e state_d;

  assign ready  = (state == SQ_IDLE) && !prt_busy;
  assign accept = cmd_valid && ready && !cmd_abort;

  always_comb begin
    state_d = state;
    unique case (state)
      SQ_IDLE:   if (accept) state_d = SQ_ADDR;
      SQ_ADDR: begin
        if (prt_exc)           state_d = SQ_IDLE;
        else if (prt_addr_ack) state_d = op_store ? SQ_STROBE : SQ_LOAD;
      end
      SQ_LOAD:   if (prt_ld_vld) state_d = SQ_IDLE;
      SQ_STROBE: state_d = SQ_DRAIN;
      SQ_DRAIN:  if (!prt_busy) state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
    if (cmd_abort) state_d = SQ_IDLE;
  end

  always_comb begin
    evt_fault = !cmd_abort && (state == SQ_ADDR) && prt_exc;
    evt_load  = !cmd_abort && (state == SQ_LOAD) && prt_ld_vld;
    evt_done  = evt_fault || evt_load || (!cmd_abort && (state == SQ_STROBE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SQ_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/ldst_seq_hold.sv
module ldst_seq_hold #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          cmd_store,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [DW-1:0] cmd_wdata,
  output logic          op_store,
  output logic [AW-1:0] addr_q,
  output logic [LW-1:0] len_q,
  output logic [DW-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_store <= 1'b0;
      addr_q   <= '0;
      len_q    <= '0;
      wdata_q  <= '0;
    end else if (load_en) begin
      op_store <= cmd_store;
      addr_q   <= cmd_addr;
      len_q    <= cmd_len;
      wdata_q  <= cmd_wdata;
    end
  end
endmodule

// File: rtl/ldst_seq_result.sv
module ldst_seq_result #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_done,
  input  logic          evt_fault,
  input  logic          evt_load,
  input  logic [DW-1:0] ld_data,
  output logic          done_q,
  output logic          fault_q,
  output logic [DW-1:0] rdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= evt_done;
      fault_q <= evt_fault;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (evt_load) rdata_q <= ld_data;
  end
endmodule

// File: rtl/ldst_port_seq.sv
module ldst_port_seq
  import ldst_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_store,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic [DW-1:0] cmd_wdata,
  input  logic          cmd_abort,
  output logic          cmd_ready,
  output logic          rsp_done,
  output logic          rsp_fault,
  output logic [DW-1:0] rsp_rdata,
  output logic          prt_ld_req,
  output logic          prt_st_req,
  output logic          prt_addr_vld,
  output logic [AW-1:0] prt_addr,
  output logic [LW-1:0] prt_len,
  input  logic          prt_busy,
  input  logic          prt_addr_ack,
  input  logic          prt_exc,
  input  logic          prt_ld_vld,
  input  logic [DW-1:0] prt_ld_data,
  output logic          prt_st_vld,
  output logic [DW-1:0] prt_st_data,
  output logic          prt_kill
);
  logic      rst_int_n;
  sq_state_e state;
  logic      accept, op_store, active;
  logic      evt_done, evt_fault, evt_load;

  ldst_seq_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ldst_seq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cmd_valid    (cmd_valid),
    .cmd_abort    (cmd_abort),
    .op_store     (op_store),
    .prt_busy     (prt_busy),
    .prt_addr_ack (prt_addr_ack),
    .prt_exc      (prt_exc),
    .prt_ld_vld   (prt_ld_vld),
    .state        (state),
    .ready        (cmd_ready),
    .accept       (accept),
    .evt_done     (evt_done),
    .evt_fault    (evt_fault),
    .evt_load     (evt_load)
  );

  ldst_seq_hold #(.AW(AW), .DW(DW), .LW(LW)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .load_en   (accept),
    .cmd_store (cmd_store),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_wdata (cmd_wdata),
    .op_store  (op_store),
    .addr_q    (prt_addr),
    .len_q     (prt_len),
    .wdata_q   (prt_st_data)
  );

  ldst_seq_result #(.DW(DW)) u_res (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt_done  (evt_done),
    .evt_fault (evt_fault),
    .evt_load  (evt_load),
    .ld_data   (prt_ld_data),
    .done_q    (rsp_done),
    .fault_q   (rsp_fault),
    .rdata_q   (rsp_rdata)
  );

  assign active       = (state != SQ_IDLE);
  assign prt_addr_vld = active;
  assign prt_ld_req   = active && !op_store;
  assign prt_st_req   = active && op_store;
  assign prt_st_vld   = (state == SQ_STROBE);
  assign prt_kill     = cmd_abort;
endmodule

// File: rtl/ldst_port_seq_chk.sv
module ldst_port_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          cmd_abort,
  input logic          rsp_done,
  input logic          rsp_fault,
  input logic [DW-1:0] rsp_rdata,
  input logic          prt_ld_req,
  input logic          prt_st_req,
  input logic          prt_addr_vld,
  input logic [AW-1:0] prt_addr,
  input logic [LW-1:0] prt_len,
  input logic          prt_busy,
  input logic          prt_addr_ack,
  input logic          prt_exc,
  input logic          prt_ld_vld,
  input logic [DW-1:0] prt_ld_data,
  input logic          prt_st_vld,
  input logic [DW-1:0] prt_st_data
);
  logic acked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             acked_q <= 1'b0;
    else if (!prt_addr_vld) acked_q <= 1'b0;
    else if (prt_addr_ack)  acked_q <= 1'b1;
  end

  p_one_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prt_ld_req, prt_st_req}));

  p_accept_raises_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_abort) |=> prt_addr_vld);

  p_ignore_when_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!prt_addr_vld && prt_busy) |=> !prt_addr_vld);

  p_hold_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_addr_vld && $past(prt_addr_vld)) |->
      ($stable(prt_addr) && $stable(prt_len) && $stable(prt_st_data)));

  p_exc_reports_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_exc && prt_addr_vld && !acked_q && !cmd_abort) |=>
      (rsp_done && rsp_fault && !prt_addr_vld));

  p_load_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_ld_vld && prt_ld_req && acked_q && !cmd_abort) |=>
      (rsp_done && !rsp_fault && rsp_rdata == $past(prt_ld_data)));

  p_store_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prt_st_vld |-> acked_q);

  p_store_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prt_st_vld |=> !prt_st_vld);

  p_store_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_st_vld && !cmd_abort) |=> (rsp_done && !rsp_fault));

  p_store_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_st_req && acked_q && prt_busy && !cmd_abort) |=> prt_st_req);

  p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_abort |=> (!prt_addr_vld && !rsp_done));

  p_rdata_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(prt_ld_vld && prt_ld_req && acked_q)) |=> $stable(rsp_rdata));
endmodule

bind ldst_port_seq ldst_port_seq_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_abort    (cmd_abort),
  .rsp_done     (rsp_done),
  .rsp_fault    (rsp_fault),
  .rsp_rdata    (rsp_rdata),
  .prt_ld_req   (prt_ld_req),
  .prt_st_req   (prt_st_req),
  .prt_addr_vld (prt_addr_vld),
  .prt_addr     (prt_addr),
  .prt_len      (prt_len),
  .prt_busy     (prt_busy),
  .prt_addr_ack (prt_addr_ack),
  .prt_exc      (prt_exc),
  .prt_ld_vld   (prt_ld_vld),
  .prt_ld_data  (prt_ld_data),
  .prt_st_vld   (prt_st_vld),
  .prt_st_data  (prt_st_data)
);

// File: tb/ldst_port_seq_test.sv
module ldst_port_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LW = 4;

  localparam logic [2:0] R_IDLE = 3'd0, R_ACK = 3'd1, R_LD = 3'd2,
                         R_WST = 3'd3, R_TAIL = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_store, cmd_abort;
  logic [AW-1:0] cmd_addr;
  logic [LW-1:0] cmd_len;
  logic [DW-1:0] cmd_wdata;
  logic          cmd_ready, rsp_done, rsp_fault;
  logic [DW-1:0] rsp_rdata;
  logic          prt_ld_req, prt_st_req, prt_addr_vld;
  logic [AW-1:0] prt_addr;
  logic [LW-1:0] prt_len;
  logic          prt_busy, prt_addr_ack, prt_exc, prt_ld_vld;
  logic [DW-1:0] prt_ld_data;
  logic          prt_st_vld, prt_kill;
  logic [DW-1:0] prt_st_data;

  int   ntest = 0;
  int   nfail = 0;
  int   d_ack = 0;
  int   d_ld = 0;
  logic want_exc = 1'b0;
  logic force_busy = 1'b0;

  logic [2:0]    rs;
  int            rcnt;
  logic          r_is_st;
  logic [DW-1:0] st_cap;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_port_seq #(.AW(AW), .DW(DW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_store(cmd_store), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .cmd_abort(cmd_abort),
    .cmd_ready(cmd_ready), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_rdata(rsp_rdata), .prt_ld_req(prt_ld_req), .prt_st_req(prt_st_req),
    .prt_addr_vld(prt_addr_vld), .prt_addr(prt_addr), .prt_len(prt_len),
    .prt_busy(prt_busy), .prt_addr_ack(prt_addr_ack), .prt_exc(prt_exc),
    .prt_ld_vld(prt_ld_vld), .prt_ld_data(prt_ld_data),
    .prt_st_vld(prt_st_vld), .prt_st_data(prt_st_data), .prt_kill(prt_kill)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 16'h5a5a, ~a};
  endfunction

  // Responder model with programmable delays
  always_comb begin
    prt_addr_ack = 1'b0;
    prt_exc      = 1'b0;
    prt_ld_vld   = 1'b0;
    prt_busy     = 1'b0;
    case (rs)
      R_IDLE: prt_busy = force_busy || prt_ld_req || prt_st_req;
      R_ACK: begin
        prt_addr_ack = (rcnt == 0) && !want_exc;
        prt_exc      = (rcnt == 0) && want_exc;
        prt_busy     = !prt_exc;
      end
      R_LD: begin
        prt_ld_vld = (rcnt == 0);
        prt_busy   = !prt_ld_vld;
      end
      R_WST:   prt_busy = 1'b1;
      default: prt_busy = 1'b0;
    endcase
    prt_ld_data = prt_ld_vld ? mem_word(prt_addr) : ~mem_word(prt_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || prt_kill) begin
      rs   <= R_IDLE;
      rcnt <= 0;
    end else begin
      case (rs)
        R_IDLE: if (prt_ld_req || prt_st_req) begin
          rs      <= R_ACK;
          rcnt    <= d_ack;
          r_is_st <= prt_st_req;
        end
        R_ACK: begin
          if (rcnt == 0) begin
            rs   <= want_exc ? R_IDLE : (r_is_st ? R_WST : R_LD);
            rcnt <= d_ld;
          end else rcnt <= rcnt - 1;
        end
        R_LD: begin
          if (rcnt == 0) rs <= R_IDLE;
          else           rcnt <= rcnt - 1;
        end
        R_WST: if (prt_st_vld) begin
          rs     <= R_TAIL;
          st_cap <= prt_st_data;
        end
        default: rs <= R_IDLE;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input bit st, input logic [AW-1:0] a, input logic [LW-1:0] ln,
                       input logic [DW-1:0] wd);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_store = st; cmd_addr = a; cmd_len = ln; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_store = !st; cmd_addr = ~a; cmd_len = ~ln; cmd_wdata = ~wd;
  endtask

  task automatic run_op(input bit st, input int da, input int dl, input bit ex,
                        input logic [AW-1:0] a, input logic [LW-1:0] ln,
                        input logic [DW-1:0] wd);
    logic [DW-1:0] prev;
    int  k_done, k_st, n_st, exp_k;
    bit  hold_ok, req_ok, vld_at_done;
    prev = rsp_rdata;
    d_ack = da; d_ld = dl; want_exc = ex;
    issue(st, a, ln, wd);
    k_done = 0; k_st = 0; n_st = 0; hold_ok = 1'b1;
    req_ok = (prt_ld_req == !st) && (prt_st_req == st) && prt_addr_vld;
    for (int k = 1; k < 40; k++) begin
      if (prt_addr_vld && (prt_addr != a || prt_len != ln || (st && prt_st_data != wd)))
        hold_ok = 1'b0;
      if (prt_st_vld) begin n_st++; k_st = k; end
      if (rsp_done) begin k_done = k; break; end
      @(negedge clk);
    end
    vld_at_done = prt_addr_vld;
    exp_k = ex ? 3 + da : (st ? 4 + da : 4 + da + dl);
    chk(req_ok, "R1 request line select", {prt_ld_req, prt_st_req}, {!st, st});
    chk(hold_ok, "R3 held address/length/data", 0, 1);
    if (ex) begin
      chk(k_done == exp_k && rsp_fault, "R4 fault completion cycle", k_done, exp_k);
      chk(!vld_at_done && n_st == 0, "R4 request dropped after exception", vld_at_done, 0);
      chk(rsp_rdata == prev, "R9 rdata kept on fault", rsp_rdata, prev);
    end else if (st) begin
      chk(k_done == exp_k && !rsp_fault, "R6 store completion cycle", k_done, exp_k);
      chk(n_st == 1 && k_st == 3 + da, "R6 single strobe after ack", k_st, 3 + da);
      chk(st_cap == wd, "R6 store data delivered", st_cap, wd);
      chk(rsp_rdata == prev, "R9 rdata kept on store", rsp_rdata, prev);
      chk(vld_at_done && prt_st_req, "R7 store held while busy", vld_at_done, 1);
      @(negedge clk);
      chk(!prt_addr_vld, "R7 store released after busy low", prt_addr_vld, 0);
    end else begin
      chk(k_done == exp_k && !rsp_fault, "R5 load completion cycle", k_done, exp_k);
      chk(rsp_rdata == mem_word(a), "R5 load data captured", rsp_rdata, mem_word(a));
      chk(!vld_at_done, "R5 request dropped after strobe", vld_at_done, 0);
    end
    @(negedge clk);
  endtask

  task automatic run_abort(input int da, input int dl, input int at, input logic [AW-1:0] a);
    logic [DW-1:0] prev;
    int n_done;
    prev = rsp_rdata;
    d_ack = da; d_ld = dl; want_exc = 1'b0;
    issue(1'b0, a, 4'h8, '0);
    for (int k = 1; k < at; k++) @(negedge clk);
    cmd_abort = 1'b1;
    #1;
    chk(prt_kill == 1'b1, "R8 abort forwarded", prt_kill, 1);
    @(negedge clk);
    cmd_abort = 1'b0;
    chk(!prt_addr_vld, "R8 idle after abort", prt_addr_vld, 0);
    n_done = 0;
    for (int k = 0; k < 10; k++) begin
      if (rsp_done || prt_addr_vld) n_done++;
      @(negedge clk);
    end
    chk(n_done == 0, "R8 no completion after abort", n_done, 0);
    chk(rsp_rdata == prev, "R9 rdata kept on abort", rsp_rdata, prev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_store = 1'b0; cmd_abort = 1'b0;
    cmd_addr = '0; cmd_len = '0; cmd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk(!rsp_done && !rsp_fault && rsp_rdata == '0, "R10 result outputs at reset",
        {rsp_done, rsp_fault}, 0);
    chk(!prt_ld_req && !prt_st_req && !prt_addr_vld && !prt_st_vld,
        "R10 port outputs at reset", {prt_ld_req, prt_st_req, prt_addr_vld}, 0);
    chk(cmd_ready, "R10 ready after reset", cmd_ready, 1);

    // R2 commands ignored while port busy
    force_busy = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_store = 1'b0; cmd_addr = 16'h1234;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!cmd_ready && !prt_addr_vld, "R2 command ignored while busy", prt_addr_vld, 0);
    end
    cmd_valid = 1'b0;
    force_busy = 1'b0;
    @(negedge clk);

    // Sweep delays for loads, stores and refused accesses
    for (int da = 0; da < 8; da++) begin
      for (int dl = 0; dl < 8; dl++)
        run_op(1'b0, da, dl, 1'b0, AW'(16'h0100 + da * 8 + dl), LW'(dl), '0);
      run_op(1'b1, da, 0, 1'b0, AW'(16'h2200 + da), LW'(da),
             DW'(32'hc0de0000 + da * 32'h111));
      run_op(1'b0, da, 0, 1'b1, AW'(16'h3300 + da), 4'h4, '0);
      run_op(1'b1, da, 0, 1'b1, AW'(16'h4400 + da), 4'h2, 32'hdead0000);
    end

    // R8 aborts: while waiting, coinciding with ack, coinciding with load strobe
    run_abort(5, 0, 2, 16'h5500);
    run_abort(0, 3, 2, 16'h5501);
    run_abort(0, 0, 3, 16'h5502);
    run_abort(0, 6, 4, 16'h5503);

    // R2 a fresh command after abort still works
    run_op(1'b0, 1, 1, 1'b0, 16'h6600, 4'h1, '0);

    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule